// File: doc/BRIEF.md
# Configurable Bridge PWM Modulator

This block turns one signed, already requantized audio sample per channel into a pair of pulse-width outputs per channel. The pair drives the two legs of an H-bridge. A counter in the system clock domain forms the carrier, and each output is high from the start of a carrier period up to a threshold. A two-bit depth code scales how far a full-scale sample moves that threshold. A two-bit mapping code selects the carrier length and chooses between complementary two-level switching and independent three-level switching.

Samples arrive on a valid/ready stream carrying all channels at once. The block offers `s_ready` only in the last cycle of each carrier period, and it does not depend on `s_valid`. The producer holds `s_valid` and `s_data` steady until it sees a cycle with both high, and that is the only cycle in which a transfer happens. If no transfer happens at a boundary, the previous sample is used again. The depth code, the mapping code and `mute` are plain levels, sampled at the same boundary. A change within a period therefore takes effect only at the next one, and no pulse is cut short.

Top module: `bridge_pwm_mod`

## Requirements
- R1: During and right after reset, the block behaves as if it holds a zero sample in two-level mode with the long carrier: `pwm_p` is high and `pwm_n` is low in the first cycle, and `s_ready` is low.
- R2: Mapping codes 00, 10 and 11 give a carrier of PERIOD cycles, and code 01 gives PERIOD/2 cycles. `s_ready` is high in the last cycle of each period only.
- R3: A transfer happens when `s_valid` and `s_ready` are both high at a rising clock edge. The sample applies to the carrier period that begins at that edge. Channel c takes bits [c*SW +: SW] of `s_data`, and bits 0 to SW-1 belong to channel 0.
- R4: If no transfer happens at a boundary, each channel keeps its previous sample for the next period.
- R5: Let L be the carrier length and h = L/2. The depth term is d = floor(s*(4+k)*h / 2^(SW+2)), where s is the signed sample and k is the depth code, so the factors are 4/8, 5/8, 6/8 and 7/8.
- R6: In two-level mode (mapping codes 00, 01 and 11), `pwm_p` is high for the first h+d cycles of the period. `pwm_n` is its exact complement in every cycle.
- R7: In three-level mode (mapping code 10), with e = floor(s*(4+k)*h / 2^(SW+3)), `pwm_p` is high for the first h+e cycles and `pwm_n` for the first h−e cycles. A zero sample gives identical waveforms.
- R8: When `mute` is high at a boundary, every channel behaves as for a zero sample during the next period. The carrier length and the switching mode still follow the mapping code.
- R9: Changes to `mute`, `mod_idx`, `map_sel` or `s_data` that occur away from the boundary do not alter the current period's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample word valid |
| s_ready | output | 1 | Block accepts a sample word (last cycle of a period) |
| s_data | input | CH*SW | Signed samples, channel 0 in the low bits |
| mod_idx | input | 2 | Depth code, factor (4+code)/8 |
| map_sel | input | 2 | 00 long/two-level, 01 short/two-level, 10 long/three-level, 11 long/two-level |
| mute | input | 1 | Active-high silence request |
| pwm_p | output | CH | Positive leg output per channel |
| pwm_n | output | CH | Negative leg output per channel |

## Verification
The sample transfer and a reconfiguration can fall on the same boundary edge. The bench provokes this by presenting a new sample while it switches `map_sel` from the long to the short carrier, and later from two-level to three-level. It judges the next period on two points: its length, taken from the position of `s_ready`, must follow the new mapping code, and its high-cycle counts must follow the new sample. A second collision arises when `mute` rises mid-period together with a change of the depth code. The counts for that period must keep the values set at its start.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  localparam logic [1:0] MAP_LONG_2L  = 2'b00;
  localparam logic [1:0] MAP_SHORT_2L = 2'b01;
  localparam logic [1:0] MAP_LONG_3L  = 2'b10;

  function automatic logic map_is_short(input logic [1:0] m);
    return m == MAP_SHORT_2L;
  endfunction

  function automatic logic map_is_3l(input logic [1:0] m);
    return m == MAP_LONG_3L;
  endfunction
endpackage

// File: rtl/bpm_carrier.sv
module bpm_carrier #(
  parameter int PERIOD = 64,
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          short_next,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          short_q
);
  localparam logic [CW-1:0] LAST_LONG  = CW'(PERIOD - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(PERIOD / 2 - 1);

  assign wrap = (cnt == (short_q ? LAST_SHORT : LAST_LONG));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      short_q <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      short_q <= short_next;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    short_q |-> cnt <= LAST_SHORT); // R2
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0); // R2
endmodule

// File: rtl/bpm_chan.sv
module bpm_chan #(
  parameter int SW = 16,
  parameter int PERIOD = 64,
  localparam int PW = $clog2(PERIOD),
  localparam int BASE_SH = SW + 3 - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          take,
  input  logic [SW-1:0] samp_in,
  input  logic [1:0]    idx,
  input  logic          short_m,
  input  logic          tri_m,
  input  logic          mute,
  input  logic [PW-1:0] cnt,
  output logic          p,
  output logic          n
);
  logic signed [SW-1:0] smp_q, smp_n;
  logic signed [SW+2:0] sx, scaled, dsh;
  logic signed [PW+1:0] dn, half, thp, thn;
  logic        [PW:0]   thp_q, thn_q;
  logic                 tri_q;
  int                   shamt;

  always_comb begin
    smp_n  = take ? samp_in : smp_q;
    sx     = {{3{smp_n[SW-1]}}, smp_n};
    scaled = (sx <<< 2) + (idx[0] ? sx : '0) + (idx[1] ? (sx <<< 1) : '0);
    shamt  = BASE_SH + (short_m ? 1 : 0) + (tri_m ? 1 : 0);
    dsh    = scaled >>> shamt;
    dn     = mute ? '0 : dsh[PW+1:0];
    half   = short_m ? (PW+2)'(PERIOD / 4) : (PW+2)'(PERIOD / 2);
    thp    = half + dn;
    thn    = half - dn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= '0;
      thp_q <= (PW+1)'(PERIOD / 2);
      thn_q <= (PW+1)'(PERIOD / 2);
      tri_q <= 1'b0;
    end else if (load) begin
      smp_q <= smp_n;
      thp_q <= thp[PW:0];
      thn_q <= thn[PW:0];
      tri_q <= tri_m;
    end
  end

  assign p = {1'b0, cnt} < thp_q;
  assign n = tri_q ? ({1'b0, cnt} < thn_q) : ~p;

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(thp_q) && $stable(thn_q) && $stable(tri_q)); // R9
  AST_MUTE_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
    load && mute |=> thp_q == thn_q); // R8
endmodule

// File: rtl/bridge_pwm_mod.sv
module bridge_pwm_mod #(
  parameter int CH = 2,
  parameter int SW = 16,
  parameter int PERIOD = 64,
  localparam int PW = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [CH*SW-1:0] s_data,
  input  logic [1:0]       mod_idx,
  input  logic [1:0]       map_sel,
  input  logic             mute,
  output logic [CH-1:0]    pwm_p,
  output logic [CH-1:0]    pwm_n
);
  import bpm_pkg::*;

  logic [PW-1:0] cnt;
  logic          wrap, short_q, fire, short_m, tri_m;

  assign short_m = map_is_short(map_sel);
  assign tri_m   = map_is_3l(map_sel);

  bpm_carrier #(.PERIOD(PERIOD)) u_car (
    .clk(clk), .rst_n(rst_n), .short_next(short_m),
    .cnt(cnt), .wrap(wrap), .short_q(short_q)
  );

  assign s_ready = wrap;
  assign fire    = s_valid && wrap;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    bpm_chan #(.SW(SW), .PERIOD(PERIOD)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(wrap), .take(fire),
      .samp_in(s_data[c*SW +: SW]), .idx(mod_idx),
      .short_m(short_m), .tri_m(tri_m), .mute(mute), .cnt(cnt),
      .p(pwm_p[c]), .n(pwm_n[c])
    );
  end

  AST_READY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> cnt == '0 && !s_ready); // R3
  AST_SHORT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready && short_m |=> short_q); // R2
endmodule

// File: tb/bridge_pwm_mod_tb.sv
module bridge_pwm_mod_tb;
  localparam int CLK_NS = 10;
  localparam int CH = 2, SW = 16, P = 64, PW = $clog2(P);
  localparam int NV = 10;
  // sL, sR, idx, map, mute, valid
  localparam int VEC [NV][6] = '{
    '{0, 0, 3, 0, 0, 1},
    '{32767, -32768, 3, 0, 0, 1},
    '{16384, -8192, 0, 0, 0, 1},
    '{16384, -16384, 1, 1, 0, 1},
    '{16384, 8192, 2, 2, 0, 1},
    '{0, 0, 2, 2, 0, 1},
    '{32767, -32768, 3, 0, 1, 1},
    '{32767, -32768, 3, 2, 1, 1},
    '{-8192, 1000, 2, 3, 0, 1},
    '{5, 5, 1, 3, 0, 0}
  };

  logic clk = 0, rst_n = 0, s_valid = 0, mute = 0;
  logic s_ready;
  logic [CH*SW-1:0] s_data = '0;
  logic [1:0] mod_idx = 2'b11, map_sel = 2'b11;
  logic [CH-1:0] pwm_p, pwm_n;
  int tests = 0, fails = 0, cyc = 0, hl = 0, hr = 0;

  always #(CLK_NS/2) clk = ~clk;

  bridge_pwm_mod #(.CH(CH), .SW(SW), .PERIOD(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .mod_idx(mod_idx), .map_sel(map_sel), .mute(mute),
    .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_hi(input int s, input int k, input int m, input bit mu,
                                    output int per, output int ph, output int nh);
    int sh, d, half;
    bit sht, tl;
    sht  = (m == 1);
    tl   = (m == 2);
    per  = sht ? P/2 : P;
    half = per / 2;
    sh   = SW + 3 - PW + (sht ? 1 : 0) + (tl ? 1 : 0);
    d    = mu ? 0 : ((s * (4 + k)) >>> sh);
    ph   = half + d;
    nh   = tl ? half - d : per - ph;
  endfunction

  task automatic run(input int sl, input int sr, input int k, input int m,
                     input bit mu, input bit v, input bit poke, input string tag);
    int per, phl, nhl, phr, nhr, cpl, cnl, cpr, cnr, bad, rdy;
    s_data  = {sr[SW-1:0], sl[SW-1:0]};
    mod_idx = k[1:0];
    map_sel = m[1:0];
    mute    = mu;
    s_valid = v;
    if (v) begin hl = sl; hr = sr; end
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0;
    expect_hi(hl, k, m, mu, per, phl, nhl);
    expect_hi(hr, k, m, mu, per, phr, nhr);
    cpl = 0; cnl = 0; cpr = 0; cnr = 0; bad = 0; rdy = 0;
    for (int i = 0; i < per; i++) begin
      if (poke && i == 3) begin
        mute = ~mu; mod_idx = ~k[1:0]; map_sel = ~m[1:0]; s_data = ~s_data;
      end
      cpl += int'(pwm_p[0]); cnl += int'(pwm_n[0]);
      cpr += int'(pwm_p[1]); cnr += int'(pwm_n[1]);
      if (m != 2 && (pwm_p[0] == pwm_n[0] || pwm_p[1] == pwm_n[1])) bad++;
      if (m == 2 && hl == 0 && pwm_p[0] != pwm_n[0]) bad++;
      if (s_ready != (i == per - 1)) rdy++;
      if (i < per - 1) @(negedge clk);
    end
    chk(rdy == 0, {"R2 period/ready ", tag}, rdy, 0);
    chk(cpl == phl, {"R5/R6/R7 pL ", tag}, cpl, phl);
    chk(cnl == nhl, {"R6/R7 nL ", tag}, cnl, nhl);
    chk(cpr == phr, {"R3 pR ", tag}, cpr, phr);
    chk(cnr == nhr, {"R3 nR ", tag}, cnr, nhr);
    chk(bad == 0, {"R6/R7 phase ", tag}, bad, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: first cycle after reset
    chk(pwm_p[0] == 1 && pwm_p[1] == 1, "R1 pwm_p", int'(pwm_p), 3);
    chk(pwm_n == 2'b00, "R1 pwm_n", int'(pwm_n), 0);
    chk(s_ready == 0, "R1 s_ready", int'(s_ready), 0);
    // table walk (R2 R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < NV; v++)
      run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4] != 0,
          VEC[v][5] != 0, 1'b0, $sformatf("vec%0d", v));
    // R9: mid-period changes to mute, depth, mapping and data are ignored
    run(20000, -20000, 2, 0, 0, 1, 1'b1, "R9 poke 2L");
    run(12000, 3000, 1, 2, 0, 1, 1'b1, "R9 poke 3L");
    // R4: no transfer, sample held across a mapping change
    run(-7, -7, 3, 1, 0, 0, 1'b0, "R4 hold short");
    // same-edge collision: new sample with carrier switch, then mode switch
    run(-30000, 30000, 3, 1, 0, 1, 1'b0, "R2 collide short");
    run(30000, -30000, 0, 2, 0, 1, 1'b0, "R7 collide 3L");
    run(-1, 1, 0, 0, 0, 1, 1'b0, "R5 tiny");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule